// File: doc/BRIEF.md
# Keyed Multi-Channel Watchdog Timer

This block is a memory-mapped watchdog. After a start command it counts down from a programmed reload value. It decrements once for each pulse of a low-frequency tick-enable input, for example a 32.768 kHz tick, where a timeout of T milliseconds needs T × 32768 / 1000 ticks. Once started, nothing short of a system reset stops it. If the count runs out, the block latches a timeout event. It raises an interrupt if that is enabled, and a fixed number of ticks later it requests a system reset.

Software keeps the timer alive through several independent request channels. Each channel is a write-only register that accepts a single 32-bit key value. A channel takes part in the reload decision only when its bit is set in the channel-enable register. The counter reloads only once every enabled channel has received the key since the previous reload. This lets several independent software tasks each prove they are alive before the timer is refreshed.

The reload value, the channel enables and the pause configuration lock as soon as the timer starts. The tick can be paused separately while the processor sleeps and while a debugger halts it.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the timer is stopped, and the status registers read as follows:
  - the run flag (0x400 bit 0) reads 0;
  - the pending mask (0x404) reads 0;
  - the event flag (0x100 bit 0) reads 0;
  - the reload register (0x504) reads RELOAD_INIT (0xFFFFFF by default);
  - the channel-enable register (0x508) reads CH_EN_INIT (channel 0 only by default);
  - the pause configuration (0x50C) reads 0;
  - `irq` and `reset_req` are 0.
- R2: A write to 0x000 with bit 0 set starts the timer and loads the count from the reload register. The run flag then reads 1. No later write clears the run flag, including a write of 0 to 0x000.
- R3: While running, the count drops by one on each effective tick. The event flag sets on the effective tick that finds the count at 1 or 0, so expiry comes max(R,1) effective ticks after the last load of a reload value R.
- R4: Channel n is the register at 0x600 + 4·n. A write to it is a valid request only if the data equals 0x6E524635, bit n of 0x508 is set, the timer is running and it has not expired. Any other write to it changes nothing.
- R5: When the last outstanding enabled channel receives a valid request, the count reloads from 0x504 on that clock edge. All request flags then clear.
- R6: Bit n of the pending mask (0x404) reads 1 while the timer runs, channel n is enabled, and channel n has not yet been written with the key since the last reload or start.
- R7: While the run flag is 1, writes to the reload register (0x504), the channel-enable register (0x508) and the pause configuration register (0x50C) are ignored.
- R8: Interrupt enable:
  - a write with bit 0 set to 0x304 sets it;
  - a write with bit 0 set to 0x308 clears it;
  - bit 0 of both addresses reads it.

  The event flag is cleared by writing 0 in bit 0 of 0x100. `irq` equals the event flag AND the enable.
- R9: `reset_req` rises RST_DELAY effective ticks (2 by default) after the expiring tick and stays high until reset. A key write after expiry does not prevent it.
- R10: Pause configuration and tick gating:
  - bit 0 of 0x50C selects running (1) or pausing (0) while `cpu_sleep` is high;
  - bit 3 of 0x50C does the same while `cpu_halt` is high;
  - a paused tick is dropped and the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable per low-frequency count tick |
| cpu_sleep | input | 1 | Processor is in sleep |
| cpu_halt | input | 1 | Processor is halted by a debugger |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Timeout interrupt |
| reset_req | output | 1 | System reset request, sticky until reset |

## Verification
The bench builds the block with its default parameters: eight request channels, a 24-bit counter and a two-tick reset delay. With these, the full channel address range decodes, and the 24-bit reset-value readback is exercised. The bench programs reload values from 0 to 5 and drives the tick input one cycle at a time, so every expiry and reset-request edge lands on a known cycle. Expiry can therefore be checked exactly after each start, key reload and paused interval.

// File: rtl/kwd_pkg.sv
`timescale 1ns/1ps
package kwd_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    // value every request channel must receive to count as a refresh
    localparam logic [DATA_W-1:0] REFRESH_KEY = 32'h6E52_4635;

    localparam logic [ADDR_W-1:0] A_START   = 12'h000;
    localparam logic [ADDR_W-1:0] A_EVENT   = 12'h100;
    localparam logic [ADDR_W-1:0] A_IE_SET  = 12'h304;
    localparam logic [ADDR_W-1:0] A_IE_CLR  = 12'h308;
    localparam logic [ADDR_W-1:0] A_RUN     = 12'h400;
    localparam logic [ADDR_W-1:0] A_PEND    = 12'h404;
    localparam logic [ADDR_W-1:0] A_RELOAD  = 12'h504;
    localparam logic [ADDR_W-1:0] A_CH_EN   = 12'h508;
    localparam logic [ADDR_W-1:0] A_PAUSE   = 12'h50C;
    localparam logic [3:0]        A_KEY_PAGE = 4'h6;

    localparam int unsigned SLEEP_RUN_BIT = 0;
    localparam int unsigned HALT_RUN_BIT  = 3;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_START,
        SEL_EVENT,
        SEL_IE_SET,
        SEL_IE_CLR,
        SEL_RUN,
        SEL_PEND,
        SEL_RELOAD,
        SEL_CH_EN,
        SEL_PAUSE,
        SEL_KEY
    } reg_sel_e;

    typedef struct packed {
        logic sleep_run;
        logic halt_run;
    } pause_cfg_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a,
                                             input int unsigned nch);
        reg_sel_e s;
        case (a)
            A_START:  s = SEL_START;
            A_EVENT:  s = SEL_EVENT;
            A_IE_SET: s = SEL_IE_SET;
            A_IE_CLR: s = SEL_IE_CLR;
            A_RUN:    s = SEL_RUN;
            A_PEND:   s = SEL_PEND;
            A_RELOAD: s = SEL_RELOAD;
            A_CH_EN:  s = SEL_CH_EN;
            A_PAUSE:  s = SEL_PAUSE;
            default: begin
                if (a[11:8] == A_KEY_PAGE && a[1:0] == 2'b00 && 32'(a[7:2]) < nch)
                    s = SEL_KEY;
                else
                    s = SEL_NONE;
            end
        endcase
        return s;
    endfunction

    function automatic logic tick_blocked(input pause_cfg_t cfg,
                                          input logic sleeping,
                                          input logic halted);
        return (sleeping & ~cfg.sleep_run) | (halted & ~cfg.halt_run);
    endfunction

endpackage

// File: rtl/kwd_regs.sv
`timescale 1ns/1ps
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned COUNT_W     = 24,
    parameter logic [31:0] RELOAD_INIT = 32'h00FF_FFFF,
    parameter logic [31:0] CH_EN_INIT  = 32'h0000_0001
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 running_i,
    input  logic                 expire_i,
    input  logic [NUM_CH-1:0]    pend_i,
    output logic                 start_o,
    output logic [NUM_CH-1:0]    key_hit_o,
    output logic [COUNT_W-1:0]   reload_val_o,
    output logic [NUM_CH-1:0]    ch_en_o,
    output pause_cfg_t           pause_cfg_o,
    output logic                 irq_o,
    output logic [DATA_W-1:0]    rdata_o
);

    reg_sel_e             sel;
    logic [COUNT_W-1:0]   reload_q;
    logic [NUM_CH-1:0]    ch_en_q;
    pause_cfg_t           pause_q;
    logic                 ie_q;
    logic                 evt_q;
    logic                 cfg_wr;
    logic                 key_ok;

    assign sel    = decode_addr(addr, NUM_CH);
    assign cfg_wr = wr_en & ~running_i;
    assign key_ok = wr_en & (sel == SEL_KEY) & (wdata == REFRESH_KEY);
    assign start_o = wr_en & (sel == SEL_START) & wdata[0] & ~running_i;

    // one comparator per channel against the word index of the address
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_key_hit
        assign key_hit_o[ch] = key_ok & (32'(addr[7:2]) == ch);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= RELOAD_INIT[COUNT_W-1:0];
            ch_en_q  <= CH_EN_INIT[NUM_CH-1:0];
            pause_q  <= '0;
        end else if (cfg_wr) begin
            case (sel)
                SEL_RELOAD: reload_q <= wdata[COUNT_W-1:0];
                SEL_CH_EN:  ch_en_q  <= wdata[NUM_CH-1:0];
                SEL_PAUSE: begin
                    pause_q.sleep_run <= wdata[SLEEP_RUN_BIT];
                    pause_q.halt_run  <= wdata[HALT_RUN_BIT];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= 1'b0;
        end else if (wr_en && sel == SEL_IE_SET && wdata[0]) begin
            ie_q <= 1'b1;
        end else if (wr_en && sel == SEL_IE_CLR && wdata[0]) begin
            ie_q <= 1'b0;
        end
    end

    // a new expiry wins over a software clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= 1'b0;
        end else if (expire_i) begin
            evt_q <= 1'b1;
        end else if (wr_en && sel == SEL_EVENT && !wdata[0]) begin
            evt_q <= 1'b0;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_EVENT:              rdata_o[0] = evt_q;
            SEL_IE_SET, SEL_IE_CLR: rdata_o[0] = ie_q;
            SEL_RUN:                rdata_o[0] = running_i;
            SEL_PEND:               rdata_o[NUM_CH-1:0] = pend_i;
            SEL_RELOAD:             rdata_o[COUNT_W-1:0] = reload_q;
            SEL_CH_EN:              rdata_o[NUM_CH-1:0] = ch_en_q;
            SEL_PAUSE: begin
                rdata_o[SLEEP_RUN_BIT] = pause_q.sleep_run;
                rdata_o[HALT_RUN_BIT]  = pause_q.halt_run;
            end
            default: ;
        endcase
    end

    assign reload_val_o = reload_q;
    assign ch_en_o      = ch_en_q;
    assign pause_cfg_o  = pause_q;
    assign irq_o        = evt_q & ie_q;

    assert_cfg_lock_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && running_i) |=> ($stable(reload_q) && $stable(ch_en_q) && $stable(pause_q)));

    assert_event_latch_R8: assert property (@(posedge clk) disable iff (rst)
        expire_i |=> evt_q);

endmodule

// File: rtl/kwd_keys.sv
`timescale 1ns/1ps
module kwd_keys #(
    parameter int unsigned NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              running_i,
    input  logic              expired_i,
    input  logic              start_i,
    input  logic [NUM_CH-1:0] key_hit_i,
    input  logic [NUM_CH-1:0] ch_en_i,
    output logic              fire_o,
    output logic [NUM_CH-1:0] pend_o
);

    logic [NUM_CH-1:0] got_q;
    logic [NUM_CH-1:0] new_hit;
    logic              live;

    assign live    = running_i & ~expired_i;
    assign new_hit = key_hit_i & ch_en_i & {NUM_CH{live}};

    // reload once the last outstanding enabled channel is served
    assign fire_o = (|new_hit) & (&(got_q | new_hit | ~ch_en_i));

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || start_i || fire_o) begin
                got_q[ch] <= 1'b0;
            end else if (new_hit[ch]) begin
                got_q[ch] <= 1'b1;
            end
        end
    end

    assign pend_o = running_i ? (ch_en_i & ~got_q) : '0;

    assert_reload_clears_R5: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> (got_q == '0));

    assert_no_stray_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (!start_i && ((key_hit_i & ch_en_i) == '0)) |=> $stable(got_q));

endmodule

// File: rtl/kwd_counter.sv
`timescale 1ns/1ps
module kwd_counter #(
    parameter int unsigned COUNT_W   = 24,
    parameter int unsigned RST_DELAY = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    input  logic               start_i,
    input  logic               fire_i,
    input  logic [COUNT_W-1:0] reload_val_i,
    output logic               running_o,
    output logic               expired_o,
    output logic               expire_o,
    output logic               rst_req_o
);

    localparam int unsigned DLY_W = $clog2(RST_DELAY + 1);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(RST_DELAY - 1);

    logic [COUNT_W-1:0] count_q;
    logic               running_q;
    logic               expired_q;
    logic [DLY_W-1:0]   dly_q;
    logic               rst_req_q;
    logic               at_end;
    logic               step;

    assign at_end   = count_q < COUNT_W'(2);
    assign step     = running_q & tick_i & ~expired_q;
    assign expire_o = step & ~fire_i & at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q   <= '0;
            running_q <= 1'b0;
            expired_q <= 1'b0;
        end else if (start_i) begin
            running_q <= 1'b1;
            count_q   <= reload_val_i;
        end else if (fire_i) begin
            count_q   <= reload_val_i;
        end else if (expire_o) begin
            count_q   <= '0;
            expired_q <= 1'b1;
        end else if (step) begin
            count_q   <= count_q - COUNT_W'(1);
        end
    end

    // grace interval between the timeout event and the reset request
    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q     <= '0;
            rst_req_q <= 1'b0;
        end else if (expired_q && tick_i && !rst_req_q) begin
            if (dly_q == DLY_LAST) begin
                rst_req_q <= 1'b1;
            end else begin
                dly_q <= dly_q + DLY_W'(1);
            end
        end
    end

    assign running_o = running_q;
    assign expired_o = expired_q;
    assign rst_req_o = rst_req_q;

    assert_run_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        running_q |=> running_q);

    assert_reset_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        rst_req_q |=> rst_req_q);

    assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !start_i && !fire_i) |=> $stable(count_q));

    assert_expire_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(expired_q) |-> (count_q == '0));

endmodule

// File: rtl/keyed_watchdog.sv
`timescale 1ns/1ps
module keyed_watchdog
    import kwd_pkg::*;
#(
    parameter int unsigned NUM_CH      = 8,
    parameter int unsigned COUNT_W     = 24,
    parameter int unsigned RST_DELAY   = 2,
    parameter logic [31:0] RELOAD_INIT = 32'h00FF_FFFF,
    parameter logic [31:0] CH_EN_INIT  = 32'h0000_0001
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    input  logic        cpu_sleep,
    input  logic        cpu_halt,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    output logic        reset_req
);

    logic               start;
    logic               fire;
    logic               running;
    logic               expired;
    logic               expire;
    logic               tick_eff;
    logic [NUM_CH-1:0]  key_hit;
    logic [NUM_CH-1:0]  ch_en;
    logic [NUM_CH-1:0]  pend;
    logic [COUNT_W-1:0] reload_val;
    pause_cfg_t         pause_cfg;

    assign tick_eff = tick_en & ~tick_blocked(pause_cfg, cpu_sleep, cpu_halt);

    kwd_regs #(
        .NUM_CH      (NUM_CH),
        .COUNT_W     (COUNT_W),
        .RELOAD_INIT (RELOAD_INIT),
        .CH_EN_INIT  (CH_EN_INIT)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (bus_wr),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .running_i    (running),
        .expire_i     (expire),
        .pend_i       (pend),
        .start_o      (start),
        .key_hit_o    (key_hit),
        .reload_val_o (reload_val),
        .ch_en_o      (ch_en),
        .pause_cfg_o  (pause_cfg),
        .irq_o        (irq),
        .rdata_o      (bus_rdata)
    );

    kwd_keys #(
        .NUM_CH (NUM_CH)
    ) u_keys (
        .clk       (clk),
        .rst       (rst),
        .running_i (running),
        .expired_i (expired),
        .start_i   (start),
        .key_hit_i (key_hit),
        .ch_en_i   (ch_en),
        .fire_o    (fire),
        .pend_o    (pend)
    );

    kwd_counter #(
        .COUNT_W   (COUNT_W),
        .RST_DELAY (RST_DELAY)
    ) u_counter (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_eff),
        .start_i      (start),
        .fire_i       (fire),
        .reload_val_i (reload_val),
        .running_o    (running),
        .expired_o    (expired),
        .expire_o     (expire),
        .rst_req_o    (reset_req)
    );

    assert_paused_no_expiry_R10: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !expired) |=> !expired);

endmodule

// File: tb/keyed_watchdog_test.sv
`timescale 1ns/1ps
module keyed_watchdog_test;

    localparam logic [31:0] KEY = 32'h6E52_4635;

    typedef enum logic [1:0] {OP_WR, OP_RD, OP_RUN, OP_PIN} op_e;

    typedef struct packed {
        op_e         op;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 50;
    localparam vec_t VEC [NV] = '{
        '{OP_RD,  12'h400, 32'd0, 32'd0, 8'd1},        // R1 not running
        '{OP_RD,  12'h504, 32'd0, 32'hFFFFFF, 8'd1},   // R1 reload reset value
        '{OP_RD,  12'h508, 32'd0, 32'd1, 8'd1},        // R1 channel 0 only
        '{OP_RD,  12'h50C, 32'd0, 32'd0, 8'd1},        // R1 pause cfg
        '{OP_RD,  12'h100, 32'd0, 32'd0, 8'd1},        // R1 event clear
        '{OP_PIN, 12'h000, 32'd0, 32'd0, 8'd1},        // R1 pins low
        '{OP_WR,  12'h504, 32'd5, 32'd0, 8'd7},
        '{OP_WR,  12'h508, 32'd5, 32'd0, 8'd7},
        '{OP_WR,  12'h304, 32'd1, 32'd0, 8'd8},
        '{OP_RD,  12'h308, 32'd0, 32'd1, 8'd8},        // R8 enable readback
        '{OP_WR,  12'h600, KEY,   32'd0, 8'd4},        // R4 key while stopped
        '{OP_RD,  12'h404, 32'd0, 32'd0, 8'd6},        // R6 nothing pending when stopped
        '{OP_WR,  12'h000, 32'd1, 32'd0, 8'd2},        // R2 start
        '{OP_RD,  12'h400, 32'd0, 32'd1, 8'd2},
        '{OP_RD,  12'h404, 32'd0, 32'd5, 8'd6},        // R6 ch0, ch2 pending
        '{OP_WR,  12'h504, 32'd9, 32'd0, 8'd7},        // R7 locked
        '{OP_RD,  12'h504, 32'd0, 32'd5, 8'd7},
        '{OP_WR,  12'h508, 32'hFF, 32'd0, 8'd7},
        '{OP_RD,  12'h508, 32'd0, 32'd5, 8'd7},
        '{OP_WR,  12'h50C, 32'd9, 32'd0, 8'd7},
        '{OP_RD,  12'h50C, 32'd0, 32'd0, 8'd7},
        '{OP_RUN, 12'h000, 32'd3, 32'd0, 8'd3},        // R3 count 5 -> 2
        '{OP_WR,  12'h600, 32'h12345678, 32'd0, 8'd4}, // R4 wrong key
        '{OP_RD,  12'h404, 32'd0, 32'd5, 8'd4},
        '{OP_WR,  12'h600, KEY,   32'd0, 8'd6},
        '{OP_RD,  12'h404, 32'd0, 32'd4, 8'd6},        // R6 ch0 served
        '{OP_WR,  12'h604, KEY,   32'd0, 8'd4},        // R4 disabled channel
        '{OP_RD,  12'h404, 32'd0, 32'd4, 8'd4},
        '{OP_WR,  12'h608, KEY,   32'd0, 8'd5},        // R5 last channel: reload
        '{OP_RD,  12'h404, 32'd0, 32'd5, 8'd5},
        '{OP_RUN, 12'h000, 32'd4, 32'd0, 8'd5},        // R5 count back to 5, now 1
        '{OP_PIN, 12'h000, 32'd0, 32'd0, 8'd5},
        '{OP_RD,  12'h100, 32'd0, 32'd0, 8'd3},
        '{OP_RUN, 12'h000, 32'd1, 32'd0, 8'd3},        // R3 expiring tick
        '{OP_RD,  12'h100, 32'd0, 32'd1, 8'd3},
        '{OP_PIN, 12'h000, 32'd0, 32'd1, 8'd8},        // R8 irq up
        '{OP_RUN, 12'h000, 32'd1, 32'd0, 8'd9},
        '{OP_PIN, 12'h000, 32'd0, 32'd1, 8'd9},        // R9 one tick after: no reset yet
        '{OP_RUN, 12'h000, 32'd1, 32'd0, 8'd9},
        '{OP_PIN, 12'h000, 32'd0, 32'd3, 8'd9},        // R9 reset request
        '{OP_WR,  12'h308, 32'd1, 32'd0, 8'd8},
        '{OP_PIN, 12'h000, 32'd0, 32'd2, 8'd8},        // R8 irq masked
        '{OP_RD,  12'h304, 32'd0, 32'd0, 8'd8},
        '{OP_WR,  12'h100, 32'd1, 32'd0, 8'd8},
        '{OP_RD,  12'h100, 32'd0, 32'd1, 8'd8},        // R8 writing 1 keeps event
        '{OP_WR,  12'h100, 32'd0, 32'd0, 8'd8},
        '{OP_RD,  12'h100, 32'd0, 32'd0, 8'd8},
        '{OP_WR,  12'h304, 32'd1, 32'd0, 8'd8},
        '{OP_WR,  12'h000, 32'd0, 32'd0, 8'd2},        // R2 cannot stop
        '{OP_RD,  12'h400, 32'd0, 32'd1, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        cpu_sleep = 1'b0;
    logic        cpu_halt = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    keyed_watchdog uut (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .cpu_sleep (cpu_sleep),
        .cpu_halt  (cpu_halt),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq),
        .reset_req (reset_req)
    );

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cpu_sleep = 1'b0;
        cpu_halt = 1'b0;
        tick_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic check_rd(input logic [11:0] a, input logic [31:0] e, input int r);
        bus_addr = a;
        #1;
        checks++;
        if (bus_rdata !== e) begin
            errors++;
            $display("FAIL R%0d read 0x%03h actual=0x%08h expected=0x%08h", r, a, bus_rdata, e);
        end
    endtask

    task automatic check_pins(input logic [1:0] e, input int r);
        #1;
        checks++;
        if ({reset_req, irq} !== e) begin
            errors++;
            $display("FAIL R%0d {reset_req,irq} actual=%b expected=%b", r, {reset_req, irq}, e);
        end
    endtask

    initial begin
        do_reset();
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR:  do_write(VEC[i].addr, VEC[i].data);
                OP_RD:  check_rd(VEC[i].addr, VEC[i].exp, int'(VEC[i].req));
                OP_RUN: run_ticks(int'(VEC[i].data));
                OP_PIN: check_pins(VEC[i].exp[1:0], int'(VEC[i].req));
                default: ;
            endcase
        end

        // R1 reset returns the block to its idle state after a run
        do_reset();
        check_rd(12'h400, 32'd0, 1);
        check_pins(2'b00, 1);

        // R10 both pause sources block ticks with configuration 0
        do_write(12'h504, 32'd3);
        do_write(12'h000, 32'd1);
        cpu_sleep = 1'b1;
        run_ticks(6);
        check_rd(12'h100, 32'd0, 10);
        cpu_sleep = 1'b0;
        cpu_halt = 1'b1;
        run_ticks(6);
        check_rd(12'h100, 32'd0, 10);
        cpu_halt = 1'b0;
        run_ticks(2);
        check_rd(12'h100, 32'd0, 3);
        run_ticks(1);
        check_rd(12'h100, 32'd1, 3);

        // R10 run-in-sleep configuration
        do_reset();
        do_write(12'h50C, 32'd1);
        check_rd(12'h50C, 32'd1, 10);
        do_write(12'h504, 32'd2);
        do_write(12'h000, 32'd1);
        cpu_sleep = 1'b1;
        run_ticks(2);
        check_rd(12'h100, 32'd1, 10);
        cpu_sleep = 1'b0;

        // R10 run-in-halt, but sleep still pauses
        do_reset();
        do_write(12'h50C, 32'd8);
        check_rd(12'h50C, 32'd8, 10);
        do_write(12'h504, 32'd2);
        do_write(12'h000, 32'd1);
        cpu_halt = 1'b1;
        cpu_sleep = 1'b1;
        run_ticks(4);
        check_rd(12'h100, 32'd0, 10);
        cpu_sleep = 1'b0;
        run_ticks(2);
        check_rd(12'h100, 32'd1, 10);
        cpu_halt = 1'b0;

        // R3 reload value 0 expires on the first tick
        do_reset();
        do_write(12'h504, 32'd0);
        do_write(12'h000, 32'd1);
        check_rd(12'h100, 32'd0, 3);
        run_ticks(1);
        check_rd(12'h100, 32'd1, 3);

        // R9 a key after expiry does not cancel the reset request
        do_reset();
        do_write(12'h504, 32'd1);
        do_write(12'h000, 32'd1);
        run_ticks(1);
        do_write(12'h600, KEY);
        run_ticks(1);
        check_pins(2'b00, 9);
        run_ticks(1);
        check_pins(2'b10, 9);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule